// File: doc/BRIEF.md
# Interrupt Enable and Pending Distributor

This block keeps the per-source interrupt state for a set of interrupt IDs (96 by default) and selects the one request that should go to the processor next. Software reaches it through a simple 32-bit word port with a combinational read path. The port gives access to a global forwarding switch, paired set and clear banks for the enable and pending bits, a read-only view of the active bits, byte-packed priorities with five stored bits each, and two configuration bits per ID that choose between level and rising-edge capture.

Peripheral lines for IDs 16 and up arrive on `irq_in`. Edge-mode IDs latch a rising input into pending. Level-mode IDs copy the input into pending on every cycle. IDs 0–15 have no input line, and only software can make them pending. A separate acknowledge/end-of-interrupt port drives the active bits. Each cycle the block looks at the IDs that are enabled and pending but not active, picks the most urgent of them, and presents it on a registered request output.

Top module: `irq_distributor`

## Requirements
- R1: The control word at byte offset 0x000, bit 0, is the forwarding switch and resets to 0. While it is 0, `req_valid` is low from the next cycle on.
- R2: Writing a 1 to bit (ID%32) of the word at 0x100+(ID/32)*4 enables that ID. Writing a 0 there changes nothing. A read of that word returns the current enables. All enables reset to 0.
- R3: Writing a 1 to bit (ID%32) of the word at 0x180+(ID/32)*4 disables that ID. A disabled ID stops requesting. A read of that word returns the same enable bits as 0x100.
- R4: For edge-mode IDs and for IDs 0–15, writing a 1 to bit (ID%32) at 0x200+(ID/32)*4 sets pending, and writing a 1 to the same bit at 0x280+(ID/32)*4 clears it. A read at either address returns the pending bits.
- R5: The priority of an ID sits in bits [8*(ID%4)+7 : 8*(ID%4)] of the word at 0x400+(ID/4)*4. Only the top five bits of each byte are stored. The low three bits read as zero. Value 0 is the most urgent. Priorities reset to 0.
- R6: The trigger code of an ID sits in bits [2*(ID%16)+1 : 2*(ID%16)] of the word at 0xC00+(ID/16)*4. IDs 0–15 always read 10, and writes do not change them. Other IDs read {mode,1}: mode 1 selects rising edge and mode 0 selects level. The reset mode is 0.
- R7: The words at 0x300+(ID/32)*4 return the active bits, and writes to them have no effect. An acknowledge with `ack_id` sets that ID's active bit and clears its pending bit if the ID is edge-mode or below 16. An end-of-interrupt with `eoi_id` clears the active bit. If both name the same ID in one cycle, the acknowledge wins.
- R8: In edge mode, an input that was 0 in one cycle and is 1 in the next sets pending. Pending then stays set until a clear write or an acknowledge. A rising input wins over a clear in the same cycle.
- R9: In level mode, pending equals the input as it was one cycle earlier. Pending-set and pending-clear writes have no effect, and an acknowledge does not clear pending.
- R10: IDs 0–15 become pending only through a pending-set write.
- R11: `req_valid`, `req_id` and `req_prio` show the ID, among those that are enabled, pending and not active, with the lowest priority value. On a tie the lower ID wins. `req_prio` is the 8-bit priority as it reads back. The output is registered, so it appears one cycle after the state that causes it. With no candidate, all three outputs are 0.
- R12: Reads of unimplemented offsets return 0, and writes to them change nothing. This covers any address with bits [1:0] not 00 and any bank word beyond the last ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the word port |
| bus_addr | input | 12 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_in | input | NUM_IDS-FIXED_IDS | Peripheral lines; bit i is ID i (i from FIXED_IDS to NUM_IDS-1) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | ID being acknowledged |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | ID_W | ID being completed |
| req_valid | output | 1 | A request is presented |
| req_id | output | ID_W | ID of the presented request |
| req_prio | output | 8 | Priority of the presented request |

## Verification
Some properties are checked on every cycle. For each edge-mode ID, a rising line must leave pending set. For each level-mode ID, pending must be the line from one cycle earlier. IDs 0–15 must never become pending without a set write. Acknowledge and end-of-interrupt must move the named active bit. A cleared switch must silence the request, and a stray write must leave every stored bank untouched.

Other behaviour only the bench scenarios can show. These are the selection order (lowest value, then lowest ID, with active IDs skipped), the one-cycle output latency, the masking of the low priority bits, the fixed trigger codes of the low IDs, and the rule that a rising edge wins over a clear in the same cycle.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int PRIO_FULL = 8;
    localparam int IDS_PER_BITWORD  = 32;
    localparam int IDS_PER_PRIOWORD = 4;
    localparam int IDS_PER_CFGWORD  = 16;

    // word-address bases (byte offset / 4)
    localparam logic [9:0] W_CTRL  = 10'h000;
    localparam logic [9:0] W_ENSET = 10'h040;
    localparam logic [9:0] W_ENCLR = 10'h060;
    localparam logic [9:0] W_PSET  = 10'h080;
    localparam logic [9:0] W_PCLR  = 10'h0A0;
    localparam logic [9:0] W_ACT   = 10'h0C0;
    localparam logic [9:0] W_PRIO  = 10'h100;
    localparam logic [9:0] W_CFG   = 10'h300;

    localparam logic [9:0] SPAN_BIT  = 10'd32;
    localparam logic [9:0] SPAN_PRIO = 10'd256;
    localparam logic [9:0] SPAN_CFG  = 10'd64;

    typedef enum logic [3:0] {
        BK_NONE, BK_CTRL, BK_ENSET, BK_ENCLR, BK_PSET,
        BK_PCLR, BK_ACT, BK_PRIO, BK_CFG
    } bank_e;

    typedef struct packed {
        bank_e      bank;
        logic [9:0] idx;
    } bank_sel_t;

    function automatic bank_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        bank_sel_t  s;
        logic [9:0] w;
        w      = a[ADDR_W-1:2];
        s.bank = BK_NONE;
        s.idx  = '0;
        if (a[1:0] == 2'b00) begin
            if (w == W_CTRL) begin
                s.bank = BK_CTRL;
            end else if (w >= W_ENSET && w < W_ENSET + SPAN_BIT) begin
                s.bank = BK_ENSET; s.idx = w - W_ENSET;
            end else if (w >= W_ENCLR && w < W_ENCLR + SPAN_BIT) begin
                s.bank = BK_ENCLR; s.idx = w - W_ENCLR;
            end else if (w >= W_PSET && w < W_PSET + SPAN_BIT) begin
                s.bank = BK_PSET; s.idx = w - W_PSET;
            end else if (w >= W_PCLR && w < W_PCLR + SPAN_BIT) begin
                s.bank = BK_PCLR; s.idx = w - W_PCLR;
            end else if (w >= W_ACT && w < W_ACT + SPAN_BIT) begin
                s.bank = BK_ACT; s.idx = w - W_ACT;
            end else if (w >= W_PRIO && w < W_PRIO + SPAN_PRIO) begin
                s.bank = BK_PRIO; s.idx = w - W_PRIO;
            end else if (w >= W_CFG && w < W_CFG + SPAN_CFG) begin
                s.bank = BK_CFG; s.idx = w - W_CFG;
            end
        end
        return s;
    endfunction

    // stored upper priority bits shown as a full byte
    function automatic logic [PRIO_FULL-1:0] prio_view(input logic [PRIO_FULL-1:0] stored,
                                                      input int lsb);
        return stored << lsb;
    endfunction

    // trigger code as read back: fixed IDs 2'b10, others {edge,1}
    function automatic logic [1:0] cfg_code(input logic fixed_id, input logic edge_mode);
        return fixed_id ? 2'b10 : {edge_mode, 1'b1};
    endfunction

endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
    import irqd_pkg::*;
#(
    parameter int NUM_IDS   = 96,
    parameter int FIXED_IDS = 16,
    parameter int PRIO_W    = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              bus_we,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    input  logic [NUM_IDS-1:0]                pend_q,
    input  logic [NUM_IDS-1:0]                act_q,
    output logic                              dist_en,
    output logic [NUM_IDS-1:0]                en_q,
    output logic [NUM_IDS-1:0]                pend_set,
    output logic [NUM_IDS-1:0]                pend_clr,
    output logic [NUM_IDS-1:0][PRIO_W-1:0]    prio_q,
    output logic [NUM_IDS-1:FIXED_IDS]        edge_q
);
    localparam int PRIO_LSB = PRIO_FULL - PRIO_W;

    bank_sel_t          sel;
    logic [NUM_IDS-1:0] en_set, en_clr;

    assign sel = decode_addr(bus_addr);

    // write-one decode for the four bit banks
    always_comb begin
        en_set   = '0;
        en_clr   = '0;
        pend_set = '0;
        pend_clr = '0;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (bus_we && int'(sel.idx) == i / IDS_PER_BITWORD
                    && bus_wdata[i % IDS_PER_BITWORD]) begin
                case (sel.bank)
                    BK_ENSET: en_set[i]   = 1'b1;
                    BK_ENCLR: en_clr[i]   = 1'b1;
                    BK_PSET:  pend_set[i] = 1'b1;
                    BK_PCLR:  pend_clr[i] = 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dist_en <= 1'b0;
            en_q    <= '0;
            prio_q  <= '0;
            edge_q  <= '0;
        end else begin
            if (bus_we && sel.bank == BK_CTRL)
                dist_en <= bus_wdata[0];
            en_q <= (en_q & ~en_clr) | en_set;
            for (int i = 0; i < NUM_IDS; i++) begin
                if (bus_we && sel.bank == BK_PRIO && int'(sel.idx) == i / IDS_PER_PRIOWORD)
                    prio_q[i] <= bus_wdata[PRIO_FULL*(i % IDS_PER_PRIOWORD) + PRIO_LSB +: PRIO_W];
            end
            for (int i = FIXED_IDS; i < NUM_IDS; i++) begin
                if (bus_we && sel.bank == BK_CFG && int'(sel.idx) == i / IDS_PER_CFGWORD)
                    edge_q[i] <= bus_wdata[2*(i % IDS_PER_CFGWORD) + 1];
            end
        end
    end

    // read mux: unimplemented words return zero
    always_comb begin
        bus_rdata = '0;
        case (sel.bank)
            BK_CTRL: bus_rdata[0] = dist_en;
            BK_ENSET, BK_ENCLR, BK_PSET, BK_PCLR, BK_ACT: begin
                for (int i = 0; i < NUM_IDS; i++) begin
                    if (int'(sel.idx) == i / IDS_PER_BITWORD) begin
                        if (sel.bank == BK_ENSET || sel.bank == BK_ENCLR)
                            bus_rdata[i % IDS_PER_BITWORD] = en_q[i];
                        else if (sel.bank == BK_ACT)
                            bus_rdata[i % IDS_PER_BITWORD] = act_q[i];
                        else
                            bus_rdata[i % IDS_PER_BITWORD] = pend_q[i];
                    end
                end
            end
            BK_PRIO: begin
                for (int i = 0; i < NUM_IDS; i++) begin
                    if (int'(sel.idx) == i / IDS_PER_PRIOWORD)
                        bus_rdata[PRIO_FULL*(i % IDS_PER_PRIOWORD) +: PRIO_FULL] =
                            prio_view(PRIO_FULL'(prio_q[i]), PRIO_LSB);
                end
            end
            BK_CFG: begin
                for (int i = 0; i < NUM_IDS; i++) begin
                    if (int'(sel.idx) == i / IDS_PER_CFGWORD) begin
                        if (i < FIXED_IDS)
                            bus_rdata[2*(i % IDS_PER_CFGWORD) +: 2] = cfg_code(1'b1, 1'b0);
                        else
                            bus_rdata[2*(i % IDS_PER_CFGWORD) +: 2] = cfg_code(1'b0, edge_q[i]);
                    end
                end
            end
            default: ;
        endcase
    end

    // R12
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        bus_we && sel.bank == BK_NONE |=>
            $stable(en_q) && $stable(prio_q) && $stable(dist_en) && $stable(edge_q));

endmodule

// File: rtl/irqd_state.sv
module irqd_state #(
    parameter int NUM_IDS   = 96,
    parameter int FIXED_IDS = 16,
    parameter int ID_W      = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_IDS-1:FIXED_IDS] irq_in,
    input  logic [NUM_IDS-1:FIXED_IDS] edge_q,
    input  logic [NUM_IDS-1:0]         pend_set,
    input  logic [NUM_IDS-1:0]         pend_clr,
    input  logic                       ack_valid,
    input  logic [ID_W-1:0]            ack_id,
    input  logic                       eoi_valid,
    input  logic [ID_W-1:0]            eoi_id,
    output logic [NUM_IDS-1:0]         pend_q,
    output logic [NUM_IDS-1:0]         act_q
);
    logic [NUM_IDS-1:0]         ack_hit, eoi_hit;
    logic [NUM_IDS-1:FIXED_IDS] irq_prev;

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
        assign ack_hit[i] = ack_valid && (ack_id == ID_W'(i));
        assign eoi_hit[i] = eoi_valid && (eoi_id == ID_W'(i));

        always_ff @(posedge clk) begin
            if (rst) act_q[i] <= 1'b0;
            else     act_q[i] <= (act_q[i] & ~eoi_hit[i]) | ack_hit[i];
        end

        if (i < FIXED_IDS) begin : g_soft
            always_ff @(posedge clk) begin
                if (rst) pend_q[i] <= 1'b0;
                else     pend_q[i] <= (pend_q[i] & ~(pend_clr[i] | ack_hit[i])) | pend_set[i];
            end
            // R10
            fixed_set_only_chk: assert property (@(posedge clk) disable iff (rst)
                !pend_set[i] |=> !$rose(pend_q[i]));
        end else begin : g_line
            logic rise;
            assign rise = irq_in[i] & ~irq_prev[i];
            always_ff @(posedge clk) begin
                if (rst) begin
                    irq_prev[i] <= 1'b0;
                    pend_q[i]   <= 1'b0;
                end else begin
                    irq_prev[i] <= irq_in[i];
                    if (edge_q[i])
                        pend_q[i] <= (pend_q[i] & ~(pend_clr[i] | ack_hit[i]))
                                     | pend_set[i] | rise;
                    else
                        pend_q[i] <= irq_in[i];
                end
            end
            // R8
            edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
                edge_q[i] && irq_in[i] && !irq_prev[i] |=> pend_q[i]);
            // R9
            level_follow_chk: assert property (@(posedge clk) disable iff (rst)
                !edge_q[i] |=> pend_q[i] == $past(irq_in[i]));
        end
    end

    // R7
    ack_marks_active_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid && int'(ack_id) < NUM_IDS |=> act_q[$past(ack_id)]);
    // R7
    eoi_clears_active_chk: assert property (@(posedge clk) disable iff (rst)
        eoi_valid && int'(eoi_id) < NUM_IDS && !(ack_valid && ack_id == eoi_id)
            |=> !act_q[$past(eoi_id)]);

endmodule

// File: rtl/irqd_pick.sv
module irqd_pick
    import irqd_pkg::*;
#(
    parameter int NUM_IDS = 96,
    parameter int PRIO_W  = 5,
    parameter int ID_W    = 7
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           dist_en,
    input  logic [NUM_IDS-1:0]             en_q,
    input  logic [NUM_IDS-1:0]             pend_q,
    input  logic [NUM_IDS-1:0]             act_q,
    input  logic [NUM_IDS-1:0][PRIO_W-1:0] prio_q,
    output logic                           req_valid,
    output logic [ID_W-1:0]                req_id,
    output logic [PRIO_FULL-1:0]           req_prio
);
    localparam int PRIO_LSB = PRIO_FULL - PRIO_W;

    logic [NUM_IDS-1:0] cand;
    logic               found;
    logic [PRIO_W-1:0]  best_p;
    logic [ID_W-1:0]    best_i;

    assign cand = en_q & pend_q & ~act_q;

    // ascending scan with strict compare: ties keep the lower ID
    always_comb begin
        found  = 1'b0;
        best_p = '1;
        best_i = '0;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (cand[i] && (!found || prio_q[i] < best_p)) begin
                found  = 1'b1;
                best_p = prio_q[i];
                best_i = ID_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !(found && dist_en)) begin
            req_valid <= 1'b0;
            req_id    <= '0;
            req_prio  <= '0;
        end else begin
            req_valid <= 1'b1;
            req_id    <= best_i;
            req_prio  <= prio_view(PRIO_FULL'(best_p), PRIO_LSB);
        end
    end

    // R1
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        !dist_en |=> !req_valid);

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_IDS   = 96,
    parameter int FIXED_IDS = 16,
    parameter int PRIO_W    = 5,
    localparam int ID_W     = $clog2(NUM_IDS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_IDS-1:FIXED_IDS] irq_in,
    input  logic                       ack_valid,
    input  logic [ID_W-1:0]            ack_id,
    input  logic                       eoi_valid,
    input  logic [ID_W-1:0]            eoi_id,
    output logic                       req_valid,
    output logic [ID_W-1:0]            req_id,
    output logic [PRIO_FULL-1:0]       req_prio
);
    logic                           dist_en;
    logic [NUM_IDS-1:0]             en_q, pend_q, act_q, pend_set, pend_clr;
    logic [NUM_IDS-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_IDS-1:FIXED_IDS]     edge_q;

    irqd_regs #(.NUM_IDS(NUM_IDS), .FIXED_IDS(FIXED_IDS), .PRIO_W(PRIO_W)) u_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_q(pend_q), .act_q(act_q),
        .dist_en(dist_en), .en_q(en_q), .pend_set(pend_set), .pend_clr(pend_clr),
        .prio_q(prio_q), .edge_q(edge_q)
    );

    irqd_state #(.NUM_IDS(NUM_IDS), .FIXED_IDS(FIXED_IDS), .ID_W(ID_W)) u_state (
        .clk(clk), .rst(rst), .irq_in(irq_in), .edge_q(edge_q),
        .pend_set(pend_set), .pend_clr(pend_clr), .ack_valid(ack_valid), .ack_id(ack_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id), .pend_q(pend_q), .act_q(act_q)
    );

    irqd_pick #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
        .clk(clk), .rst(rst), .dist_en(dist_en), .en_q(en_q), .pend_q(pend_q),
        .act_q(act_q), .prio_q(prio_q), .req_valid(req_valid), .req_id(req_id),
        .req_prio(req_prio)
    );

endmodule

// File: tb/irq_distributor_bench.sv
`timescale 1ns/1ps
module irq_distributor_bench;

    localparam int NV = 31;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 32'h0,        32'h0,        4'd1},   // R1 reset
        '{1'b0, 12'h100, 32'h0,        32'h0,        4'd2},   // R2 reset
        '{1'b1, 12'h104, 32'h00000011, 32'h0,        4'd2},   // R2
        '{1'b0, 12'h104, 32'h0,        32'h00000011, 4'd2},   // R2
        '{1'b1, 12'h104, 32'h0,        32'h0,        4'd2},   // R2 zeros
        '{1'b0, 12'h104, 32'h0,        32'h00000011, 4'd2},   // R2
        '{1'b1, 12'h184, 32'h00000001, 32'h0,        4'd3},   // R3
        '{1'b0, 12'h104, 32'h0,        32'h00000010, 4'd3},   // R3
        '{1'b0, 12'h184, 32'h0,        32'h00000010, 4'd3},   // R3
        '{1'b1, 12'h408, 32'hFFFFFFFF, 32'h0,        4'd5},   // R5
        '{1'b0, 12'h408, 32'h0,        32'hF8F8F8F8, 4'd5},   // R5
        '{1'b1, 12'h40C, 32'h12345678, 32'h0,        4'd5},   // R5
        '{1'b0, 12'h40C, 32'h0,        32'h10305078, 4'd5},   // R5
        '{1'b0, 12'hC00, 32'h0,        32'hAAAAAAAA, 4'd6},   // R6
        '{1'b1, 12'hC00, 32'h55555555, 32'h0,        4'd6},   // R6
        '{1'b0, 12'hC00, 32'h0,        32'hAAAAAAAA, 4'd6},   // R6
        '{1'b0, 12'hC04, 32'h0,        32'h55555555, 4'd6},   // R6
        '{1'b1, 12'hC04, 32'hFFFFFFFF, 32'h0,        4'd6},   // R6
        '{1'b0, 12'hC04, 32'h0,        32'hFFFFFFFF, 4'd6},   // R6
        '{1'b1, 12'hC04, 32'h0,        32'h0,        4'd6},   // R6
        '{1'b0, 12'hC04, 32'h0,        32'h55555555, 4'd6},   // R6
        '{1'b1, 12'h300, 32'hFFFFFFFF, 32'h0,        4'd7},   // R7
        '{1'b0, 12'h300, 32'h0,        32'h0,        4'd7},   // R7
        '{1'b1, 12'h10C, 32'hFFFFFFFF, 32'h0,        4'd12},  // R12
        '{1'b0, 12'h10C, 32'h0,        32'h0,        4'd12},  // R12
        '{1'b1, 12'h010, 32'hFFFFFFFF, 32'h0,        4'd12},  // R12
        '{1'b0, 12'h010, 32'h0,        32'h0,        4'd12},  // R12
        '{1'b0, 12'h460, 32'h0,        32'h0,        4'd12},  // R12
        '{1'b0, 12'h106, 32'h0,        32'h0,        4'd12},  // R12
        '{1'b1, 12'h105, 32'hFFFFFFFF, 32'h0,        4'd12},  // R12
        '{1'b0, 12'h104, 32'h0,        32'h00000010, 4'd12}   // R12
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [95:16] irq_in = '0;
    logic        ack_valid = 1'b0, eoi_valid = 1'b0;
    logic [6:0]  ack_id = '0, eoi_id = '0;
    logic        req_valid;
    logic [6:0]  req_id;
    logic [7:0]  req_prio;

    int nchk = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    irq_distributor u_irq_distributor (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .ack_valid(ack_valid), .ack_id(ack_id), .eoi_valid(eoi_valid),
        .eoi_id(eoi_id), .req_valid(req_valid), .req_id(req_id), .req_prio(req_prio)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string rq, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(rq, bus_rdata, exp);
    endtask

    task automatic req_check(input string rq, input logic v, input int id, input logic [7:0] p);
        check({rq, " valid"}, 32'(req_valid), 32'(v));
        check({rq, " id"},    32'(req_id),    32'(id));
        check({rq, " prio"},  32'(req_prio),  32'(p));
    endtask

    task automatic pulse_ack(input int id);
        @(negedge clk);
        ack_valid = 1'b1; ack_id = 7'(id);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic pulse_eoi(input int id);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_id = 7'(id);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog R1-R12 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        do_reset();
        @(negedge clk);
        req_check("R11 reset", 1'b0, 0, 8'h00);

        for (int k = 0; k < NV; k++) begin
            if (VECS[k].wr) wr(VECS[k].addr, VECS[k].data);
            else rd_check($sformatf("R%0d vec%0d", VECS[k].rq, k), VECS[k].addr, VECS[k].exp);
        end

        do_reset();
        rd_check("R2 after reset", 12'h104, 32'h0);

        // R4: software set/clear on edge-mode ID 40
        wr(12'hC08, 32'h00020000);
        rd_check("R6 id40 edge", 12'hC08, 32'h55575555);
        wr(12'h204, 32'h00000100);
        rd_check("R4 set", 12'h204, 32'h00000100);
        rd_check("R4 alias", 12'h284, 32'h00000100);
        wr(12'h284, 32'h00000100);
        rd_check("R4 clr", 12'h204, 32'h0);

        // R8: edge capture and hold
        @(negedge clk); irq_in[40] = 1'b1;
        settle();
        rd_check("R8 rise", 12'h204, 32'h00000100);
        @(negedge clk); irq_in[40] = 1'b0;
        settle();
        rd_check("R8 hold", 12'h204, 32'h00000100);
        wr(12'h284, 32'h00000100);
        rd_check("R8 cleared", 12'h204, 32'h0);
        // R8: rise and clear in the same cycle, rise wins
        @(negedge clk);
        irq_in[40] = 1'b1; bus_we = 1'b1; bus_addr = 12'h284; bus_wdata = 32'h00000100;
        @(negedge clk);
        bus_we = 1'b0;
        rd_check("R8 rise beats clear", 12'h204, 32'h00000100);
        @(negedge clk); irq_in[40] = 1'b0;
        wr(12'h284, 32'h00000100);

        // R9: level ID 50
        @(negedge clk); irq_in[50] = 1'b1;
        settle();
        rd_check("R9 follow high", 12'h204, 32'h00040000);
        wr(12'h284, 32'h00040000);
        rd_check("R9 clear ignored", 12'h204, 32'h00040000);
        @(negedge clk); irq_in[50] = 1'b0;
        settle();
        rd_check("R9 follow low", 12'h204, 32'h0);
        wr(12'h204, 32'h00040000);
        rd_check("R9 set ignored", 12'h204, 32'h0);

        // R10: fixed ID 3 made pending by software
        wr(12'h200, 32'h00000008);
        rd_check("R10 soft set", 12'h200, 32'h00000008);

        // R11: selection
        wr(12'h428, 32'h00000040);
        wr(12'h430, 32'h00400000);
        wr(12'h400, 32'h80000000);
        wr(12'h100, 32'h00000008);
        wr(12'h104, 32'h00040100);
        settle();
        req_check("R1 switch off", 1'b0, 0, 8'h00);
        wr(12'h000, 32'h00000001);
        req_check("R11 latency", 1'b0, 0, 8'h00);
        @(negedge clk);
        req_check("R11 single", 1'b1, 3, 8'h80);
        @(negedge clk); irq_in[50] = 1'b1;
        settle();
        req_check("R11 lower value", 1'b1, 50, 8'h40);
        wr(12'h204, 32'h00000100);
        settle();
        req_check("R11 tie lower id", 1'b1, 40, 8'h40);
        pulse_ack(40);
        settle();
        rd_check("R7 active set", 12'h304, 32'h00000100);
        rd_check("R7 ack clears edge pend", 12'h204, 32'h00040000);
        req_check("R11 active skipped", 1'b1, 50, 8'h40);
        pulse_ack(50);
        settle();
        rd_check("R9 level pend kept", 12'h204, 32'h00040000);
        rd_check("R7 two active", 12'h304, 32'h00040100);
        req_check("R11 fall back", 1'b1, 3, 8'h80);
        pulse_eoi(40);
        settle();
        rd_check("R7 eoi", 12'h304, 32'h00040000);
        wr(12'h180, 32'h00000008);
        settle();
        req_check("R3 disabled", 1'b0, 0, 8'h00);
        wr(12'h100, 32'h00000008);
        settle();
        req_check("R2 re-enabled", 1'b1, 3, 8'h80);
        wr(12'h000, 32'h00000000);
        settle();
        req_check("R1 switch cleared", 1'b0, 0, 8'h00);

        finish_run();
    end

endmodule